// File: doc/BRIEF.md
# Cached Dual-Port Bank Controller

This block presents one read port and one write port that may both be used in every clock cycle, while the storage behind them consists only of single-ported banks. A read and a write aimed at different banks proceed side by side, each on its own bank. When both target the same bank, the bank's one port goes to the read and the write is steered into a sideband cache. The cache holds one bank's worth of entries and is indexed by the same entry index as the banks.

Each cache slot carries a valid flag and the number of the bank it belongs to. If a diverted write lands on a slot that holds live data for another bank, that older entry is copied back to its own bank in the same cycle. That copy can never clash with the read, because the read targets the bank being written and the victim belongs to a different bank. Reads check the cache first, so data waiting in the cache is always the data returned. Direct writes to an address that currently sits in the cache invalidate that slot.

Reads are synchronous: data appears one cycle after the request. A read and a write to the same address in the same cycle return the value held before the write. The arrays are behavioural single-port memories.

Top module: `bankcache_dpmem`

## Requirements
- R1: `rd_valid` is 1 in the cycle after a cycle with `rd_en`=1 and 0 after a cycle with `rd_en`=0; `rd_data` is valid while `rd_valid` is 1. `rd_valid` is 0 after reset.
- R2: A read of (bank, index) returns the last value written to that (bank, index), whatever path that write took.
- R3: A write whose bank is not the bank read in the same cycle (or with no read that cycle) is stored directly into its bank, in the same cycle as the read. Each bank sees at most one access per cycle.
- R4: A write whose bank equals the bank read in the same cycle does not touch the bank array. It is stored in cache slot `wr_idx`, tagged with `wr_bank` and marked valid.
- R5: If that cache slot held valid data for a different bank, the old data is written back to that bank at index `wr_idx` in the same cycle, and never to the bank being read.
- R6: If that cache slot already held valid data for the same bank, it is overwritten and nothing is written back.
- R7: A read whose index selects a valid slot tagged with the read bank returns the cache data rather than the bank data.
- R8: A direct write to a (bank, index) held valid in the cache invalidates that slot, so later reads return the new value.
- R9: A read and a write to the same (bank, index) in the same cycle return the old value; the next read returns the new value.
- R10: Synchronous active-low reset clears every cache valid flag. Diverted data not yet written back is lost, and reads return the bank contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_en | input | 1 | Read request this cycle |
| rd_bank | input | BANK_W | Bank of the read |
| rd_idx | input | IDX_W | Entry index of the read |
| rd_valid | output | 1 | Read data valid (one cycle after `rd_en`) |
| rd_data | output | DATA_W | Read data |
| wr_en | input | 1 | Write request this cycle |
| wr_bank | input | BANK_W | Bank of the write |
| wr_idx | input | IDX_W | Entry index of the write |
| wr_data | input | DATA_W | Write data |

## Verification
A wrong tag, valid flag or routing choice does not show up at once. It shows up as a wrong `rd_data` on the first later read of the affected address, which may come many cycles after the fault. The bench therefore keeps a behavioural reference model and compares every read, one cycle after its request, under dense same-bank traffic that forces diversion and eviction. Resets are placed in the middle of the traffic. A reset drops the cache contents and exposes what was actually written into the banks, so a diverted write that wrongly reached a bank, or a victim that was never written back, shows up on the next read of that address.

// File: rtl/dpm_pkg.sv
// Package: shared types for the cached dual-port bank controller.
// Assumes nothing beyond the 1800-2017 language.
package dpm_pkg;

    // Where the write of the current cycle is steered.
    typedef enum logic [1:0] {
        WR_NONE   = 2'd0,
        WR_DIRECT = 2'd1,
        WR_DIVERT = 2'd2
    } wr_route_e;

endpackage

// File: rtl/dpm_sp_bank.sv
// Module: dpm_sp_bank
// Behavioural single-port memory bank with one access per cycle: either a
// write or a registered read. Read data holds between reads.
// Assumes the caller never requests more than one access per cycle.
module dpm_sp_bank #(
    parameter int DEPTH  = 64,
    parameter int DATA_W = 16,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              en,
    input  logic              we,
    input  logic [IDX_W-1:0]  addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] mem [DEPTH];

    // Single port: write on en&we, else registered read on en.
    always_ff @(posedge clk) begin
        if (en) begin
            if (we) begin
                mem[addr] <= wdata;
            end else begin
                rdata <= mem[addr];
            end
        end
    end

endmodule

// File: rtl/dpm_tag_store.sv
// Module: dpm_tag_store
// Valid flags and bank tags of the sideband cache, one pair per index.
// Two combinational lookups (read index, write index). One slot is set or
// cleared per cycle. Assumes set_en and clr_en are never both high.
module dpm_tag_store #(
    parameter int DEPTH  = 64,
    parameter int BANK_W = 2,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic [IDX_W-1:0]  wr_idx,
    output logic              rd_slot_valid,
    output logic [BANK_W-1:0] rd_slot_tag,
    output logic              wr_slot_valid,
    output logic [BANK_W-1:0] wr_slot_tag,
    input  logic              set_en,
    input  logic [BANK_W-1:0] set_tag,
    input  logic              clr_en,
    output logic [DEPTH-1:0]  valid_vec
);

    logic [BANK_W-1:0] tag_mem [DEPTH];

    // Valid flags: cleared by reset, set on diversion, cleared on direct hit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_vec <= '0;
        end else if (set_en) begin
            valid_vec[wr_idx] <= 1'b1;
        end else if (clr_en) begin
            valid_vec[wr_idx] <= 1'b0;
        end
    end

    // Tags: written whenever a slot is claimed by a diverted write.
    always_ff @(posedge clk) begin
        if (set_en) begin
            tag_mem[wr_idx] <= set_tag;
        end
    end

    // Lookups at both indices, seeing the state before this cycle's update.
    always_comb begin
        rd_slot_valid = valid_vec[rd_idx];
        rd_slot_tag   = tag_mem[rd_idx];
        wr_slot_valid = valid_vec[wr_idx];
        wr_slot_tag   = tag_mem[wr_idx];
    end

endmodule

// File: rtl/dpm_cache_data.sv
// Module: dpm_cache_data
// Data side of the sideband cache: one entry per index, one write port and
// two combinational read ports (read hit and victim fetch).
// Assumes reads see the contents from before the write of the same cycle.
module dpm_cache_data #(
    parameter int DEPTH  = 64,
    parameter int DATA_W = 16,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [IDX_W-1:0]  widx,
    input  logic [DATA_W-1:0] wdata,
    input  logic [IDX_W-1:0]  ridx_a,
    output logic [DATA_W-1:0] rdata_a,
    input  logic [IDX_W-1:0]  ridx_b,
    output logic [DATA_W-1:0] rdata_b
);

    logic [DATA_W-1:0] mem [DEPTH];

    // Store diverted write data.
    always_ff @(posedge clk) begin
        if (we) begin
            mem[widx] <= wdata;
        end
    end

    // Two independent read ports.
    always_comb begin
        rdata_a = mem[ridx_a];
        rdata_b = mem[ridx_b];
    end

endmodule

// File: rtl/dpm_router.sv
// Module: dpm_router
// Combinational steering. Decides per cycle which bank serves the read, where
// the write goes (bank or cache), whether a cache victim is written back, and
// how the tag store changes. Assumes NUM_BANKS is a power of two.
module dpm_router
    import dpm_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    localparam int BANK_W   = $clog2(NUM_BANKS)
) (
    input  logic                 rd_en,
    input  logic [BANK_W-1:0]    rd_bank,
    input  logic                 wr_en,
    input  logic [BANK_W-1:0]    wr_bank,
    input  logic                 wr_slot_valid,
    input  logic [BANK_W-1:0]    wr_slot_tag,
    output wr_route_e            route,
    output logic                 evict_en,
    output logic [BANK_W-1:0]    evict_bank,
    output logic [NUM_BANKS-1:0] bank_rd_vec,
    output logic [NUM_BANKS-1:0] bank_direct_vec,
    output logic [NUM_BANKS-1:0] bank_victim_vec,
    output logic                 tag_set,
    output logic                 tag_clr
);

    logic conflict;
    logic slot_same;

    // Classify the write and the victim.
    always_comb begin
        conflict  = rd_en && wr_en && (rd_bank == wr_bank);
        slot_same = wr_slot_valid && (wr_slot_tag == wr_bank);
        if (!wr_en) begin
            route = WR_NONE;
        end else if (conflict) begin
            route = WR_DIVERT;
        end else begin
            route = WR_DIRECT;
        end
        evict_en   = (route == WR_DIVERT) && wr_slot_valid && !slot_same;
        evict_bank = wr_slot_tag;
        tag_set    = (route == WR_DIVERT);
        tag_clr    = (route == WR_DIRECT) && slot_same;
    end

    // One-hot bank request vectors.
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_req
        always_comb begin
            bank_rd_vec[b]     = rd_en && (rd_bank == BANK_W'(b));
            bank_direct_vec[b] = (route == WR_DIRECT) && (wr_bank == BANK_W'(b));
            bank_victim_vec[b] = evict_en && (evict_bank == BANK_W'(b));
        end
    end

endmodule

// File: rtl/bankcache_dpmem.sv
// Module: bankcache_dpmem (top)
// One-read/one-write-per-cycle memory built from NUM_BANKS single-port banks
// and one bank-sized write-diversion cache with victim writeback.
// Read latency is one cycle, with read-before-write at the same address.
// Assumes NUM_BANKS and DEPTH are powers of two, NUM_BANKS >= 2.
module bankcache_dpmem
    import dpm_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int DEPTH     = 64,
    parameter int DATA_W    = 16,
    localparam int BANK_W   = $clog2(NUM_BANKS),
    localparam int IDX_W    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [BANK_W-1:0] rd_bank,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [BANK_W-1:0] wr_bank,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data
);

    logic                 rd_slot_valid, wr_slot_valid;
    logic [BANK_W-1:0]    rd_slot_tag, wr_slot_tag;
    logic [DEPTH-1:0]     valid_vec;
    wr_route_e            route;
    logic                 divert;
    logic                 evict_en;
    logic [BANK_W-1:0]    evict_bank;
    logic [NUM_BANKS-1:0] bank_rd_vec, bank_direct_vec, bank_victim_vec;
    logic                 tag_set, tag_clr;
    logic [DATA_W-1:0]    cache_rd_word, victim_word;
    logic [DATA_W-1:0]    bank_rdata [NUM_BANKS];
    logic                 hit_q;
    logic [DATA_W-1:0]    cache_q;
    logic [BANK_W-1:0]    rbank_q;
    logic                 rd_hit;

    dpm_tag_store #(.DEPTH(DEPTH), .BANK_W(BANK_W)) u_tags (
        .clk           (clk),
        .rst_n         (rst_n),
        .rd_idx        (rd_idx),
        .wr_idx        (wr_idx),
        .rd_slot_valid (rd_slot_valid),
        .rd_slot_tag   (rd_slot_tag),
        .wr_slot_valid (wr_slot_valid),
        .wr_slot_tag   (wr_slot_tag),
        .set_en        (tag_set),
        .set_tag       (wr_bank),
        .clr_en        (tag_clr),
        .valid_vec     (valid_vec)
    );

    dpm_router #(.NUM_BANKS(NUM_BANKS)) u_router (
        .rd_en           (rd_en),
        .rd_bank         (rd_bank),
        .wr_en           (wr_en),
        .wr_bank         (wr_bank),
        .wr_slot_valid   (wr_slot_valid),
        .wr_slot_tag     (wr_slot_tag),
        .route           (route),
        .evict_en        (evict_en),
        .evict_bank      (evict_bank),
        .bank_rd_vec     (bank_rd_vec),
        .bank_direct_vec (bank_direct_vec),
        .bank_victim_vec (bank_victim_vec),
        .tag_set         (tag_set),
        .tag_clr         (tag_clr)
    );

    assign divert = (route == WR_DIVERT);

    dpm_cache_data #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_cache (
        .clk     (clk),
        .we      (divert),
        .widx    (wr_idx),
        .wdata   (wr_data),
        .ridx_a  (rd_idx),
        .rdata_a (cache_rd_word),
        .ridx_b  (wr_idx),
        .rdata_b (victim_word)
    );

    // Banks: read uses rd_idx; direct writes and victims both use wr_idx.
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic              b_en, b_we;
        logic [IDX_W-1:0]  b_addr;
        logic [DATA_W-1:0] b_wdata;

        // Per-bank port request.
        always_comb begin
            b_we    = bank_direct_vec[b] || bank_victim_vec[b];
            b_en    = bank_rd_vec[b] || b_we;
            b_addr  = bank_rd_vec[b] ? rd_idx : wr_idx;
            b_wdata = bank_victim_vec[b] ? victim_word : wr_data;
        end

        dpm_sp_bank #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_bank (
            .clk   (clk),
            .en    (b_en),
            .we    (b_we),
            .addr  (b_addr),
            .wdata (b_wdata),
            .rdata (bank_rdata[b])
        );
    end

    // Cache hit for the current read.
    assign rd_hit = rd_en && rd_slot_valid && (rd_slot_tag == rd_bank);

    // Read pipeline stage: valid flag, hit flag, cache word and bank select.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            hit_q    <= 1'b0;
        end else begin
            rd_valid <= rd_en;
            hit_q    <= rd_hit;
        end
        if (rd_en) begin
            cache_q <= cache_rd_word;
            rbank_q <= rd_bank;
        end
    end

    // Output mux: cache word on a hit, else the selected bank's read data.
    always_comb begin
        rd_data = hit_q ? cache_q : bank_rdata[rbank_q];
    end

endmodule

// File: rtl/dpm_checker.sv
// Module: dpm_checker
// Concurrent assertions on the port timing, write steering and bank-port
// exclusivity of bankcache_dpmem. Attached by the bind statement below.
module dpm_checker #(
    parameter int NUM_BANKS = 4,
    parameter int DEPTH     = 64,
    localparam int BANK_W   = $clog2(NUM_BANKS)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 rd_en,
    input logic [BANK_W-1:0]    rd_bank,
    input logic                 wr_en,
    input logic [BANK_W-1:0]    wr_bank,
    input logic                 rd_valid,
    input logic                 evict_en,
    input logic [BANK_W-1:0]    evict_bank,
    input logic                 wr_slot_valid,
    input logic [BANK_W-1:0]    wr_slot_tag,
    input logic [NUM_BANKS-1:0] bank_rd_vec,
    input logic [NUM_BANKS-1:0] bank_direct_vec,
    input logic [NUM_BANKS-1:0] bank_victim_vec,
    input logic [DEPTH-1:0]     valid_vec
);

    p_rd_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid);

    p_rd_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rd_valid);

    p_direct_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !(rd_en && rd_bank == wr_bank)) |-> (bank_direct_vec[wr_bank] && $onehot(bank_direct_vec)));

    p_single_port_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((bank_rd_vec & (bank_direct_vec | bank_victim_vec)) == '0) && ((bank_direct_vec & bank_victim_vec) == '0));

    p_divert_no_bank_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && wr_en && rd_bank == wr_bank) |-> (bank_direct_vec == '0));

    p_victim_off_read_bank_r5: assert property (@(posedge clk) disable iff (!rst_n)
        evict_en |-> (evict_bank != rd_bank) && $onehot(bank_victim_vec) && !bank_rd_vec[evict_bank]);

    p_evict_other_tag_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && wr_en && rd_bank == wr_bank && wr_slot_valid && wr_slot_tag != wr_bank) |-> evict_en);

    p_same_tag_no_evict_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_slot_valid && wr_slot_tag == wr_bank) |-> (bank_victim_vec == '0));

    p_reset_clears_r10: assert property (@(posedge clk)
        !rst_n |=> (valid_vec == '0));

endmodule

bind bankcache_dpmem dpm_checker #(.NUM_BANKS(NUM_BANKS), .DEPTH(DEPTH)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .rd_en           (rd_en),
    .rd_bank         (rd_bank),
    .wr_en           (wr_en),
    .wr_bank         (wr_bank),
    .rd_valid        (rd_valid),
    .evict_en        (evict_en),
    .evict_bank      (evict_bank),
    .wr_slot_valid   (wr_slot_valid),
    .wr_slot_tag     (wr_slot_tag),
    .bank_rd_vec     (bank_rd_vec),
    .bank_direct_vec (bank_direct_vec),
    .bank_victim_vec (bank_victim_vec),
    .valid_vec       (valid_vec)
);

// File: tb/bankcache_dpmem_bench.sv
// Bench: directed scenarios plus random traffic. Every read is compared with
// a behavioural model of banks and cache slots kept in the bench.
module bankcache_dpmem_bench;

    localparam int NB = 4;
    localparam int DP = 64;
    localparam int DW = 16;
    localparam int BW = $clog2(NB);
    localparam int IW = $clog2(DP);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rd_en = 1'b0, wr_en = 1'b0;
    logic [BW-1:0] rd_bank = '0, wr_bank = '0;
    logic [IW-1:0] rd_idx = '0, wr_idx = '0;
    logic [DW-1:0] wr_data = '0;
    logic          rd_valid;
    logic [DW-1:0] rd_data;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    // Behavioural reference state.
    int m_bank [NB][DP];
    bit m_sv   [DP];
    int m_sb   [DP];
    int m_sd   [DP];

    always #2.5 clk = ~clk;

    bankcache_dpmem #(.NUM_BANKS(NB), .DEPTH(DP), .DATA_W(DW)) u_bankcache_dpmem (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_en   (rd_en),
        .rd_bank (rd_bank),
        .rd_idx  (rd_idx),
        .rd_valid(rd_valid),
        .rd_data (rd_data),
        .wr_en   (wr_en),
        .wr_bank (wr_bank),
        .wr_idx  (wr_idx),
        .wr_data (wr_data)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // One cycle of traffic, called at a negedge; checks its own read result.
    task automatic op(input bit re, input int rb, input int ri,
                      input bit we, input int wb, input int wi,
                      input int wd, input string req);
        int exp;
        rd_en = re; rd_bank = BW'(rb); rd_idx = IW'(ri);
        wr_en = we; wr_bank = BW'(wb); wr_idx = IW'(wi); wr_data = DW'(wd);
        exp = (m_sv[ri] && m_sb[ri] == rb) ? m_sd[ri] : m_bank[rb][ri];
        if (we) begin
            if (re && rb == wb) begin
                if (m_sv[wi] && m_sb[wi] != wb) m_bank[m_sb[wi]][wi] = m_sd[wi];
                m_sv[wi] = 1'b1; m_sb[wi] = wb; m_sd[wi] = wd & 16'hFFFF;
            end else begin
                m_bank[wb][wi] = wd & 16'hFFFF;
                if (m_sv[wi] && m_sb[wi] == wb) m_sv[wi] = 1'b0;
            end
        end
        @(negedge clk);
        check("R1", int'(rd_valid), int'(re));
        if (re) check(req, int'(rd_data), exp);
        rd_en = 1'b0; wr_en = 1'b0;
    endtask

    task automatic do_reset();
        rd_en = 1'b0; wr_en = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        check("R1", int'(rd_valid), 0);
        rst_n = 1'b1;
        for (int i = 0; i < DP; i++) m_sv[i] = 1'b0;
    endtask

    // Watchdog: an expired run is a failure and still reports the summary.
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < DP; i++) m_sv[i] = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R1", int'(rd_valid), 0);
        rst_n = 1'b1;

        // Preload every location directly (no read in flight).
        for (int b = 0; b < NB; b++)
            for (int i = 0; i < DP; i++)
                op(0, 0, 0, 1, b, i, (b * 256 + i) ^ 16'h5A00, "R2");

        // R3: different banks in one cycle; the write goes to its bank.
        op(1, 1, 5, 1, 2, 5, 16'hA001, "R3");
        op(1, 2, 5, 0, 0, 0, 0, "R3");

        // R4 and R7: same-bank conflict diverts; the cached value is read back.
        op(1, 1, 3, 1, 1, 7, 16'hB002, "R4");
        op(1, 1, 7, 0, 0, 0, 0, "R7");

        // R5: slot 7 holds bank 1; a conflict on bank 2 evicts it to bank 1.
        op(1, 2, 0, 1, 2, 7, 16'hC003, "R5");
        op(1, 1, 7, 0, 0, 0, 0, "R5");
        op(1, 2, 7, 0, 0, 0, 0, "R7");

        // R6: same-tag slot overwritten in place; bank 1 copy is unaffected.
        op(1, 2, 1, 1, 2, 7, 16'hD004, "R6");
        op(1, 2, 7, 0, 0, 0, 0, "R6");
        op(1, 1, 7, 0, 0, 0, 0, "R6");

        // R8: direct write to the cached address invalidates the slot.
        op(0, 0, 0, 1, 2, 7, 16'hE005, "R8");
        op(1, 2, 7, 0, 0, 0, 0, "R8");

        // R9: same address, same cycle gives old data, then new.
        op(1, 3, 9, 1, 3, 9, 16'hF006, "R9");
        op(1, 3, 9, 0, 0, 0, 0, "R9");
        op(1, 0, 1, 1, 0, 1, 16'h1107, "R9");
        op(1, 0, 1, 0, 0, 0, 0, "R9");

        // R10 and R4: a diverted write is lost on reset; the bank keeps its old value.
        op(1, 0, 2, 1, 0, 12, 16'h2208, "R4");
        op(1, 3, 3, 1, 3, 20, 16'h3309, "R4");
        op(1, 1, 3, 1, 1, 20, 16'h440A, "R5");
        do_reset();
        op(1, 0, 12, 0, 0, 0, 0, "R10");
        op(1, 3, 20, 0, 0, 0, 0, "R5");
        op(1, 1, 20, 0, 0, 0, 0, "R10");

        // R2: random traffic biased toward same-bank conflicts, with resets.
        for (int n = 0; n < 4000; n++) begin
            int rb, wb;
            rb = $urandom_range(NB - 1);
            wb = ($urandom_range(1) == 1) ? rb : $urandom_range(NB - 1);
            op($urandom_range(4) != 0, rb, $urandom_range(15),
               $urandom_range(4) != 0, wb, $urandom_range(15),
               $urandom_range(16'hFFFF), "R2");
            if (n == 1500 || n == 3000) do_reset();
        end

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule